// File: doc/BRIEF.md
# Nonvolatile Store and Recall Controller for a Four-Channel DAC

This block sits behind a serial command decoder in a multi-channel DAC. For each channel it keeps a working code register, which drives the converter, and a persistent shadow register. The shadow register is modelled as flip-flops with a programmable programming time. The decoder gives the block single-cycle strobes for the arm, write and recall commands, together with the channel address, the data byte and the chip-select level.

A write frame always updates the working register. A write frame that closes while the arm latch is set also programs the shadow register, which takes a fixed number of cycles. A frame must first set the latch, and it does so when chip select rises at the end of an arm frame. The latch clears as soon as programming starts. A ready output stays low while programming runs and while the power-up copy of every shadow register into the working registers is in progress. No command is accepted during that time. A mute input forces every output code to zero without touching the working registers.

The sequencer has three states. ST_LOAD copies one channel per cycle after reset. ST_IDLE accepts commands. ST_PROG waits on the programming timer. The transitions are load_done (ST_LOAD to ST_IDLE after the last channel), prog_launch (ST_IDLE to ST_PROG on a chip-select rise that closes an armed write frame) and prog_done (ST_PROG to ST_IDLE when the timer expires, which also commits the byte).

Top module: `nvstore_ctrl`

## Requirements
- R1: After reset release, ready is low for exactly NUM_CH cycles while channel 0 up to channel NUM_CH-1 are loaded from the shadow registers. The shadow registers reset to NV_INIT (0x80), so every output code then reads 0x80.
- R2: In ST_IDLE, a wr_stb with the latch clear writes din into the working register of channel addr (binary channel index). The new code shows on dac_code[addr*8 +: 8] in the cycle after the strobe, and ready stays high after chip select rises.
- R3: A frame that carries arm_stb and ends with a chip-select rise sets the latch. The next write frame's chip-select rise makes ready low for exactly WR_CYCLES cycles.
- R4: When programming completes, the shadow register of the addressed channel holds the written byte, and the other shadow registers are unchanged. This is seen through later recalls.
- R5: The latch clears when programming starts, so a second write frame with no new arm frame does not make ready low.
- R6: An rcl_stb in ST_IDLE copies the shadow register of channel addr into its working register, visible in the next cycle. Other channels do not change.
- R7: While ready is low, wr_stb, rcl_stb, arm_stb and chip-select rises are ignored. Output codes hold, and no arm is recorded.
- R8: While mute is high every output code is 0. When mute is released, the codes return to the unchanged working register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, treated as power-up |
| cs_n | input | 1 | Chip-select level, low during a frame |
| arm_stb | input | 1 | Arm command decoded (one cycle) |
| wr_stb | input | 1 | Write command with full data byte received (one cycle) |
| rcl_stb | input | 1 | Recall command decoded (one cycle) |
| addr | input | ADDR_W | Channel index of the command |
| din | input | DW | Data byte of a write command |
| mute | input | 1 | Forces all output codes to zero while high |
| ready | output | 1 | High when idle; low while loading or programming |
| dac_code | output | NUM_CH*DW | Output codes, channel c at [c*DW +: DW] |

## Verification
Unarmed write frames, arm-then-write pairs, repeated writes after one arm, recalls and mute pulses are mixed in random order. Comparing ready-low lengths separates writes that start programming from writes that only touch the working register. Recalls after programming show whether the right shadow register took the byte and whether the others kept theirs. A directed run sends write, recall, arm and chip-select activity during programming, which shows whether anything leaks through while the block is busy. Mute pulses then show that forcing the codes to zero leaves the working registers intact.

// File: rtl/nvstore_pkg.sv
package nvstore_pkg;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_IDLE = 2'd1,
        ST_PROG = 2'd2
    } seq_state_t;

endpackage

// File: rtl/nvstore_timer.sv
module nvstore_timer #(
    parameter int unsigned WR_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int unsigned CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= CW'(WR_CYCLES - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign done = run_q && (cnt_q == '0);

endmodule

// File: rtl/nvstore_seq.sv
module nvstore_seq
    import nvstore_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DW     = 8,
    parameter int unsigned ADDR_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              arm_stb,
    input  logic              wr_stb,
    input  logic              rcl_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     din,
    input  logic              timer_done,
    output logic              timer_start,
    output logic              dr_we,
    output logic [ADDR_W-1:0] dr_idx,
    output logic [DW-1:0]     dr_wdata,
    output logic              cp_en,
    output logic [ADDR_W-1:0] cp_idx,
    output logic              nv_we,
    output logic [ADDR_W-1:0] nv_idx,
    output logic [DW-1:0]     nv_wdata,
    output logic              ready
);
    localparam logic [ADDR_W-1:0] LAST_CH = ADDR_W'(NUM_CH - 1);

    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] ld_idx_q;
    logic              cs_q;
    logic              cs_rise;
    logic              armed_q;
    logic              pend_arm_q;
    logic              pend_wr_q;
    logic [ADDR_W-1:0] pend_idx_q;
    logic [DW-1:0]     pend_data_q;
    logic              prog_launch;

    assign cs_rise = cs_n && !cs_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: if (ld_idx_q == LAST_CH) state_d = ST_IDLE;                   // load_done
            ST_IDLE: if (cs_rise && pend_wr_q && armed_q && !pend_arm_q)
                         state_d = ST_PROG;                                        // prog_launch
            ST_PROG: if (timer_done) state_d = ST_IDLE;                            // prog_done
            default: state_d = ST_IDLE;
        endcase
    end

    assign prog_launch = (state_q == ST_IDLE) && (state_d == ST_PROG);

    // state register and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_LOAD;
            ld_idx_q    <= '0;
            cs_q        <= 1'b1;
            armed_q     <= 1'b0;
            pend_arm_q  <= 1'b0;
            pend_wr_q   <= 1'b0;
            pend_idx_q  <= '0;
            pend_data_q <= '0;
        end else begin
            state_q <= state_d;
            cs_q    <= cs_n;
            if (state_q == ST_LOAD && ld_idx_q != LAST_CH) begin
                ld_idx_q <= ld_idx_q + 1'b1;
            end
            if (state_q == ST_IDLE) begin
                if (arm_stb) pend_arm_q <= 1'b1;
                if (wr_stb) begin
                    pend_wr_q   <= 1'b1;
                    pend_idx_q  <= addr;
                    pend_data_q <= din;
                end
                if (cs_rise) begin
                    pend_arm_q <= 1'b0;
                    pend_wr_q  <= 1'b0;
                    if (pend_arm_q) begin
                        armed_q <= 1'b1;
                    end else if (prog_launch) begin
                        armed_q <= 1'b0;
                    end
                end
            end
        end
    end

    // outputs
    always_comb begin
        ready       = (state_q == ST_IDLE);
        timer_start = prog_launch;
        dr_we       = (state_q == ST_IDLE) && wr_stb;
        dr_idx      = addr;
        dr_wdata    = din;
        cp_en       = (state_q == ST_LOAD) || ((state_q == ST_IDLE) && rcl_stb);
        cp_idx      = (state_q == ST_LOAD) ? ld_idx_q : addr;
        nv_we       = (state_q == ST_PROG) && timer_done;
        nv_idx      = pend_idx_q;
        nv_wdata    = pend_data_q;
    end

endmodule

// File: rtl/nvstore_bank.sv
module nvstore_bank #(
    parameter int unsigned NUM_CH  = 4,
    parameter int unsigned DW      = 8,
    parameter int unsigned ADDR_W  = $clog2(NUM_CH),
    parameter logic [DW-1:0] NV_INIT = 8'h80
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dr_we,
    input  logic [ADDR_W-1:0]    dr_idx,
    input  logic [DW-1:0]        dr_wdata,
    input  logic                 cp_en,
    input  logic [ADDR_W-1:0]    cp_idx,
    input  logic                 nv_we,
    input  logic [ADDR_W-1:0]    nv_idx,
    input  logic [DW-1:0]        nv_wdata,
    output logic [NUM_CH*DW-1:0] work_flat
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [DW-1:0] work_q;
        logic [DW-1:0] shadow_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                work_q <= '0;
            end else if (dr_we && dr_idx == ADDR_W'(ch)) begin
                work_q <= dr_wdata;
            end else if (cp_en && cp_idx == ADDR_W'(ch)) begin
                work_q <= shadow_q;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q <= NV_INIT;
            end else if (nv_we && nv_idx == ADDR_W'(ch)) begin
                shadow_q <= nv_wdata;
            end
        end

        assign work_flat[ch*DW +: DW] = work_q;
    end

endmodule

// File: rtl/nvstore_mute.sv
module nvstore_mute #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DW     = 8
) (
    input  logic                 mute,
    input  logic [NUM_CH*DW-1:0] work_flat,
    output logic [NUM_CH*DW-1:0] code_flat
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign code_flat[ch*DW +: DW] = mute ? '0 : work_flat[ch*DW +: DW];
    end

endmodule

// File: rtl/nvstore_ctrl.sv
module nvstore_ctrl #(
    parameter int unsigned   NUM_CH    = 4,
    parameter int unsigned   DW        = 8,
    parameter int unsigned   WR_CYCLES = 20,
    parameter int unsigned   ADDR_W    = $clog2(NUM_CH),
    parameter logic [DW-1:0] NV_INIT   = 8'h80
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 arm_stb,
    input  logic                 wr_stb,
    input  logic                 rcl_stb,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DW-1:0]        din,
    input  logic                 mute,
    output logic                 ready,
    output logic [NUM_CH*DW-1:0] dac_code
);
    logic              timer_start, timer_done;
    logic              dr_we, cp_en, nv_we;
    logic [ADDR_W-1:0] dr_idx, cp_idx, nv_idx;
    logic [DW-1:0]     dr_wdata, nv_wdata;
    logic [NUM_CH*DW-1:0] work_flat;

    nvstore_seq #(.NUM_CH(NUM_CH), .DW(DW), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
        .arm_stb(arm_stb), .wr_stb(wr_stb), .rcl_stb(rcl_stb),
        .addr(addr), .din(din),
        .timer_done(timer_done), .timer_start(timer_start),
        .dr_we(dr_we), .dr_idx(dr_idx), .dr_wdata(dr_wdata),
        .cp_en(cp_en), .cp_idx(cp_idx),
        .nv_we(nv_we), .nv_idx(nv_idx), .nv_wdata(nv_wdata),
        .ready(ready)
    );

    nvstore_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(timer_start), .done(timer_done)
    );

    nvstore_bank #(.NUM_CH(NUM_CH), .DW(DW), .ADDR_W(ADDR_W), .NV_INIT(NV_INIT)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .dr_we(dr_we), .dr_idx(dr_idx), .dr_wdata(dr_wdata),
        .cp_en(cp_en), .cp_idx(cp_idx),
        .nv_we(nv_we), .nv_idx(nv_idx), .nv_wdata(nv_wdata),
        .work_flat(work_flat)
    );

    nvstore_mute #(.NUM_CH(NUM_CH), .DW(DW)) u_mute (
        .mute(mute), .work_flat(work_flat), .code_flat(dac_code)
    );

endmodule

// File: rtl/nvstore_ctrl_chk.sv
module nvstore_ctrl_chk #(
    parameter int unsigned NUM_CH    = 4,
    parameter int unsigned DW        = 8,
    parameter int unsigned WR_CYCLES = 20
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mute,
    input logic                 ready,
    input logic [NUM_CH*DW-1:0] dac_code
);
    localparam int unsigned CYW = $clog2(NUM_CH + 1) + 1;
    localparam int unsigned LW  = $clog2(WR_CYCLES + 2) + 1;

    logic [CYW-1:0] cyc_q;
    logic           up_done_q;
    logic [LW-1:0]  low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q     <= '0;
            up_done_q <= 1'b0;
            low_run_q <= '0;
        end else begin
            if (cyc_q < CYW'(NUM_CH + 1)) cyc_q <= cyc_q + 1'b1;
            if (ready) up_done_q <= 1'b1;
            if (ready || !up_done_q) low_run_q <= '0;
            else if (low_run_q < LW'(WR_CYCLES + 1)) low_run_q <= low_run_q + 1'b1;
        end
    end

    // R1: power-up copy keeps ready low
    a_r1_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q < CYW'(NUM_CH)) |-> !ready);

    // R3: a programming window never outlasts WR_CYCLES cycles
    a_r3_prog_len: assert property (@(posedge clk) disable iff (!rst_n)
        up_done_q |-> (low_run_q <= LW'(WR_CYCLES)));

    // R7: codes frozen while busy after power-up
    a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (up_done_q && !ready && $stable(mute)) |-> $stable(dac_code));

    // R8: mute zeroes every output code
    a_r8_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mute |-> (dac_code == '0));

endmodule

bind nvstore_ctrl nvstore_ctrl_chk #(.NUM_CH(NUM_CH), .DW(DW), .WR_CYCLES(WR_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .mute(mute), .ready(ready), .dac_code(dac_code)
);

// File: tb/nvstore_ctrl_tb.sv
module nvstore_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 4;
    localparam int DW         = 8;
    localparam int WR_CYCLES  = 20;
    localparam int NV_INIT    = 8'h80;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cs_n = 1'b1;
    logic                 arm_stb = 1'b0, wr_stb = 1'b0, rcl_stb = 1'b0;
    logic [1:0]           addr = '0;
    logic [DW-1:0]        din = '0;
    logic                 mute = 1'b0;
    logic                 ready;
    logic [NUM_CH*DW-1:0] dac_code;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int exp_work [NUM_CH];
    int exp_nv   [NUM_CH];
    bit armed = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvstore_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .arm_stb(arm_stb), .wr_stb(wr_stb),
        .rcl_stb(rcl_stb), .addr(addr), .din(din), .mute(mute),
        .ready(ready), .dac_code(dac_code)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int code_of(input int ch);
        return int'(dac_code[ch*DW +: DW]);
    endfunction

    task automatic chk_codes(input string req);
        for (int ch = 0; ch < NUM_CH; ch++) chk(req, code_of(ch), mute ? 0 : exp_work[ch]);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // count negedges with ready low after the chip-select rise
    task automatic end_frame(output int busy);
        cs_n = 1'b1;
        busy = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (ready) break;
            busy++;
        end
    endtask

    task automatic op_arm();
        int busy;
        cs_n = 1'b0; tick(2);
        arm_stb = 1'b1; tick(1); arm_stb = 1'b0; tick(2);
        end_frame(busy);
        chk("R3 arm frame no busy", busy, 0);
        armed = 1'b1;
    endtask

    task automatic op_write(input int ch, input int val);
        int busy;
        cs_n = 1'b0; tick(2);
        addr = 2'(ch); din = 8'(val); wr_stb = 1'b1; tick(1); wr_stb = 1'b0;
        exp_work[ch] = val;
        chk("R2 working code after strobe", code_of(ch), val);
        tick(2);
        end_frame(busy);
        if (armed) begin
            chk("R3 programming length", busy, WR_CYCLES);
            exp_nv[ch] = val;
            armed = 1'b0;
        end else begin
            chk("R2 R5 unarmed write no busy", busy, 0);
        end
        chk_codes("R2 codes after write");
    endtask

    task automatic op_recall(input int ch);
        int busy;
        cs_n = 1'b0; tick(2);
        addr = 2'(ch); rcl_stb = 1'b1; tick(1); rcl_stb = 1'b0;
        exp_work[ch] = exp_nv[ch];
        chk_codes("R4 R6 recall");
        tick(1);
        end_frame(busy);
        chk("R6 recall no busy", busy, 0);
    endtask

    task automatic op_mute();
        mute = 1'b1; tick(1);
        for (int ch = 0; ch < NUM_CH; ch++) chk("R8 muted code", code_of(ch), 0);
        tick(2);
        mute = 1'b0; tick(1);
        chk_codes("R8 released codes");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int ch = 0; ch < NUM_CH; ch++) begin
            exp_work[ch] = NV_INIT;
            exp_nv[ch]   = NV_INIT;
        end
        tick(2);
        chk("R1 ready low in reset", int'(ready), 0);
        rst_n = 1'b1;
        for (int i = 0; i < NUM_CH; i++) begin
            @(negedge clk);
            chk("R1 ready low during load", int'(ready), (i == NUM_CH - 1) ? 1 : 0);
        end
        chk_codes("R1 codes after load");

        // directed: unarmed write then recall restores shadow value
        op_write(2, 8'h3C);
        op_recall(2);
        // directed: arm, program, second write not programmed
        op_arm();
        op_write(1, 8'hF0);
        op_write(1, 8'h0F);
        op_recall(1);
        chk("R5 shadow kept first byte", code_of(1), 8'hF0);
        op_recall(0);
        chk("R4 untouched shadow", code_of(0), NV_INIT);

        // directed: activity while busy is ignored
        begin
            int busy;
            op_arm();
            cs_n = 1'b0; tick(2);
            addr = 2'd3; din = 8'h11; wr_stb = 1'b1; tick(1); wr_stb = 1'b0;
            exp_work[3] = 8'h11;
            tick(1);
            cs_n = 1'b1; tick(1);
            chk("R3 ready low after armed write", int'(ready), 0);
            cs_n = 1'b0; tick(1);
            addr = 2'd0; din = 8'hEE; wr_stb = 1'b1; tick(1); wr_stb = 1'b0;
            addr = 2'd3; rcl_stb = 1'b1; tick(1); rcl_stb = 1'b0;
            arm_stb = 1'b1; tick(1); arm_stb = 1'b0;
            end_frame(busy);
            for (int i = 0; i < 200 && !ready; i++) tick(1);
            chk_codes("R7 codes held while busy");
            exp_nv[3] = 8'h11; armed = 1'b0;
            op_write(0, 8'h42);   // R7: arm during busy was ignored
            op_recall(3);
            chk("R4 programmed channel 3", code_of(3), 8'h11);
        end
        op_mute();

        // random mix
        for (int it = 0; it < 60; it++) begin
            int op = int'($urandom_range(0, 4));
            int ch = int'($urandom_range(0, NUM_CH - 1));
            int v  = int'($urandom_range(0, 255));
            case (op)
                0: op_write(ch, v);
                1: begin op_arm(); op_write(ch, v); end
                2: op_recall(ch);
                3: op_mute();
                default: op_arm();
            endcase
        end
        for (int ch = 0; ch < NUM_CH; ch++) begin
            op_recall(ch);
            chk("R4 final shadow", code_of(ch), exp_nv[ch]);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule